// File: doc/BRIEF.md
# Two-Stage SPI Serial Clock Divider

The block derives an SPI serial clock from the main clock in two steps. A power-of-two prescaler divides the main clock by 2, 4, 8 or 16, according to a 2-bit select. A second counter then counts a programmable number of prescaler ticks before it turns SCK over. As a result, each SCK half-period lasts (BRG+1)·(2<<DIV) main-clock cycles, and the full SCK period is twice that. This gives SCK periods from 20 to 2048 main-clock cycles.

Alongside the SCK level, the block drives two single-cycle strobes for a shift engine. One marks the edge that leaves the idle level (the leading edge). The other marks the edge that returns to the idle level (the trailing edge). The polarity input picks the idle level.

While the enable is low, SCK rests at its idle level and both counters sit at zero. The divider fields and the polarity may change only while the block is disabled. After enable is asserted, the first SCK edge comes one full half-period later.

Top module: `spi_sck_div`

## Requirements
- R1: While en_i is low, sck_o equals cpol_i from the next clock on, lead_o and trail_o stay 0, and the counters are cleared.
- R2: While enabled, every SCK half-period lasts exactly (B+1)*(2<<div_sel_i) main-clock cycles, where B is the effective baud value.
- R3: div_sel_i (2 bits) selects a prescale of 2, 4, 8 or 16 main-clock cycles per tick for the codes 0, 1, 2 and 3.
- R4: baud_i (6 bits) holds the tick count minus one. The values 0 to 3 behave as 4, and the values 4 to 63 are used as written.
- R5: lead_o and trail_o are each exactly one main-clock cycle wide and are never high together.
- R6: lead_o is high in the cycle where sck_o first shows the level opposite to cpol_i. trail_o is high in the cycle where sck_o first returns to cpol_i.
- R7: Counting the rising clock edges that sample en_i high, the first SCK edge appears at edge number (B+1)*(2<<div_sel_i), and that first edge is a leading edge. Every re-enable restarts this count from zero.
- R8: The fastest setting (div_sel_i=0, baud_i=4) gives a 20-cycle SCK period. The slowest setting (div_sel_i=3, baud_i=63) gives a 2048-cycle SCK period.
- R9: While enabled, sck_o never changes without lead_o or trail_o in the same cycle.
- R10: During reset, sck_o, lead_o and trail_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low holds SCK idle and clears the counters |
| cpol_i | input | 1 | Idle level of SCK |
| div_sel_i | input | 2 | Prescale select; the prescale is 2<<div_sel_i |
| baud_i | input | 6 | Ticks per half-period minus one; values below 4 act as 4 |
| sck_o | output | 1 | Serial clock level |
| lead_o | output | 1 | One-cycle strobe on the edge leaving idle |
| trail_o | output | 1 | One-cycle strobe on the edge returning to idle |

## Verification
The assertions assume that cpol_i, div_sel_i and baud_i stay constant while en_i is high. Under that assumption, any SCK edge seen while the block is enabled comes from the divider and not from a polarity change. The assertions also assume that the polarity is 0 while reset is released, because the reset value of sck_o is 0.

The bench keeps to these assumptions. It changes the fields only at a falling clock edge while en_i is low, and it waits several cycles before raising en_i. It holds cpol_i at 0 through reset.

// File: rtl/spi_sck_div_pkg.sv
package spi_sck_div_pkg;
  localparam int DIV_W   = 2;
  localparam int BAUD_W  = 6;
  localparam int BAUD_LO = 4;
endpackage

// File: rtl/spi_sck_prescale.sv
module spi_sck_prescale #(
  parameter int DIV_W = spi_sck_div_pkg::DIV_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_sel_i,
  output logic             tick_o
);
  localparam int PRE_MAX = 2 << ((1 << DIV_W) - 1);
  localparam int CW      = $clog2(PRE_MAX);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  always_comb begin
    last   = CW'((32'd2 << div_sel_i) - 32'd1);
    tick_o = run_i && (cnt_q == last);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_sck_halfper.sv
module spi_sck_halfper #(
  parameter int BAUD_W  = spi_sck_div_pkg::BAUD_W,
  parameter int BAUD_LO = spi_sck_div_pkg::BAUD_LO
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic [BAUD_W-1:0] baud_i,
  output logic              flip_o
);
  logic [BAUD_W-1:0] cnt_q;
  logic [BAUD_W-1:0] baud_eff;

  always_comb begin
    baud_eff = (baud_i < BAUD_W'(BAUD_LO)) ? BAUD_W'(BAUD_LO) : baud_i;
    flip_o   = tick_i && (cnt_q == baud_eff);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!run_i)   cnt_q <= '0;
    else if (tick_i)   cnt_q <= flip_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_sck_out.sv
module spi_sck_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic cpol_i,
  input  logic flip_i,
  output logic sck_o,
  output logic lead_o,
  output logic trail_o
);
  logic sck_q, lead_q, trail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q   <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else if (!run_i) begin
      sck_q   <= cpol_i;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      // strobe registered with the level so both appear in one cycle
      lead_q  <= flip_i && (sck_q == cpol_i);
      trail_q <= flip_i && (sck_q != cpol_i);
      if (flip_i) sck_q <= ~sck_q;
    end
  end

  assign sck_o   = sck_q;
  assign lead_o  = lead_q;
  assign trail_o = trail_q;
endmodule

// File: rtl/spi_sck_div.sv
module spi_sck_div #(
  parameter int DIV_W   = spi_sck_div_pkg::DIV_W,
  parameter int BAUD_W  = spi_sck_div_pkg::BAUD_W,
  parameter int BAUD_LO = spi_sck_div_pkg::BAUD_LO
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cpol_i,
  input  logic [DIV_W-1:0]  div_sel_i,
  input  logic [BAUD_W-1:0] baud_i,
  output logic              sck_o,
  output logic              lead_o,
  output logic              trail_o
);
  logic tick, flip;

  spi_sck_prescale #(.DIV_W(DIV_W)) i_pre (
    .clk_i, .rst_ni, .run_i(en_i), .div_sel_i, .tick_o(tick)
  );

  spi_sck_halfper #(.BAUD_W(BAUD_W), .BAUD_LO(BAUD_LO)) i_half (
    .clk_i, .rst_ni, .run_i(en_i), .tick_i(tick), .baud_i, .flip_o(flip)
  );

  spi_sck_out i_out (
    .clk_i, .rst_ni, .run_i(en_i), .cpol_i, .flip_i(flip),
    .sck_o, .lead_o, .trail_o
  );
endmodule

// File: rtl/spi_sck_div_chk.sv
module spi_sck_div_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic cpol_i,
  input logic sck_o,
  input logic lead_o,
  input logic trail_o
);
  a_r1_idle_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(en_i)) |-> (sck_o == $past(cpol_i) && !lead_o && !trail_o));

  a_r5_lead_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_o |=> !lead_o);

  a_r5_trail_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trail_o |=> !trail_o);

  a_r5_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lead_o && trail_o));

  a_r6_lead_leaves_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_o |-> (sck_o != cpol_i && sck_o != $past(sck_o)));

  a_r6_trail_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trail_o |-> (sck_o == cpol_i && sck_o != $past(sck_o)));

  a_r9_no_silent_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(en_i) && sck_o != $past(sck_o)) |-> (lead_o || trail_o));

  always_comb begin
    if (!rst_ni) begin
      a_r10_reset_quiet: assert (!sck_o && !lead_o && !trail_o);
    end
  end
endmodule

bind spi_sck_div spi_sck_div_chk i_chk (
  .clk_i, .rst_ni, .en_i, .cpol_i, .sck_o, .lead_o, .trail_o
);

// File: tb/test_spi_sck_div.sv
`timescale 1ns/1ps
module test_spi_sck_div;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic cpol = 1'b0;
  logic [1:0] div_sel = '0;
  logic [5:0] baud = '0;
  logic sck, lead, trail;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spi_sck_div i_spi_sck_div (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .cpol_i(cpol),
    .div_sel_i(div_sel), .baud_i(baud),
    .sck_o(sck), .lead_o(lead), .trail_o(trail)
  );

  // {div_sel, baud, cpol, expected half-period}
  localparam int NV = 9;
  localparam int VEC [NV][4] = '{
    '{0,  4, 0,   10},  // R8 fastest, R3 code 0
    '{0,  5, 1,   12},  // R2
    '{1,  4, 0,   20},  // R3 code 1
    '{2, 10, 1,   88},  // R3 code 2
    '{3,  7, 0,  128},  // R3 code 3
    '{0,  0, 1,   10},  // R4 clamp of 0
    '{1,  3, 0,   20},  // R4 clamp of 3
    '{2, 63, 0,  512},  // R2
    '{3, 63, 1, 1024}   // R8 slowest
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // count falling edges until sck leaves lvl; flag any strobe seen before that
  task automatic wait_change(input logic lvl, output int n, output bit stray);
    n = 0;
    stray = 1'b0;
    do begin
      @(negedge clk);
      n++;
      if (sck == lvl && (lead || trail)) stray = 1'b1;
    end while (sck == lvl && n < 5000);
  endtask

  task automatic run_vec(input int d, input int b, input int p, input int h);
    int n1, n2;
    bit s1, s2;
    en = 1'b0;
    div_sel = 2'(d); baud = 6'(b); cpol = p[0];
    repeat (3) @(negedge clk);
    check(sck == cpol && !lead && !trail, "R1 idle level", int'(sck), p);
    en = 1'b1;
    wait_change(cpol, n1, s1);
    check(n1 == h, "R7 first edge delay / R2 half-period", n1, h);
    check(lead && !trail, "R6 lead strobe on leading edge", int'(lead), 1);
    check(s1 == 1'b0, "R9 strobe without edge", int'(s1), 0);
    @(negedge clk);
    check(!lead && !trail, "R5 strobe width", int'(lead), 0);
    wait_change(~cpol, n2, s2);
    check(n2 + 1 == h, "R2 second half-period", n2 + 1, h);
    check(trail && !lead, "R6 trail strobe on return edge", int'(trail), 1);
    check(s2 == 1'b0, "R9 strobe without edge", int'(s2), 0);
    @(negedge clk);
    check(!trail, "R5 trail strobe width", int'(trail), 0);
    en = 1'b0;
  endtask

  initial begin
    int n, cnt;
    bit s;
    repeat (3) @(negedge clk);
    check(!sck && !lead && !trail, "R10 reset outputs", int'(sck), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);

    // disable mid-run, then re-enable restarts the count (R1, R7)
    div_sel = 2'd0; baud = 6'd4; cpol = 1'b1;
    repeat (3) @(negedge clk);
    en = 1'b1;
    repeat (15) @(negedge clk);
    check(sck == 1'b0, "R2 sck left idle", int'(sck), 0);
    en = 1'b0;
    @(negedge clk);
    check(sck == 1'b1 && !lead && !trail, "R1 drop to idle on disable", int'(sck), 1);
    cnt = 0;
    repeat (40) begin
      @(negedge clk);
      if (lead || trail || sck != 1'b1) cnt++;
    end
    check(cnt == 0, "R1 quiet while disabled", cnt, 0);
    en = 1'b1;
    repeat (7) @(negedge clk);
    en = 1'b0;
    repeat (2) @(negedge clk);
    en = 1'b1;
    wait_change(1'b1, n, s);
    check(n == 10, "R7 re-enable restarts from zero", n, 10);
    check(lead, "R7 first edge is leading", int'(lead), 1);
    en = 1'b0;
    @(negedge clk);

    // full period at the fastest setting (R8)
    cpol = 1'b0;
    repeat (2) @(negedge clk);
    en = 1'b1;
    wait_change(1'b0, n, s);
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!lead && cnt < 100);
    check(cnt == 20, "R8 fastest full period", cnt, 20);
    en = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule